// File: doc/BRIEF.md
# Byte-to-word IDE port bridge

This block lets an 8-bit CPU I/O bus talk to a 16-bit parallel ATA (IDE) device through three port codes. Port code 0 is a write-only control register that sets the IDE register address, the two active-low chip selects and the active-low device reset. Port codes 1 and 2 carry data. A 16-bit word is split across them through an internal byte latch. A read on port 1 runs a real IDE read: it returns the high byte and stores the low byte in the latch. A read on port 2 returns the latch. A write on port 1 only fills the latch. A write on port 2 runs a real IDE write, with the latch as the high byte and the written byte as the low byte.

A full 512-byte sector moves as 256 such pairs. A `byte_mode` input selects an 8-bit-only variant. In that mode both data ports run a single 8-bit transfer on the low data lines and the latch is not used. IDE strobes come from a sequencer with parameterised setup, strobe and hold lengths. The CPU side sees `cpu_busy` while a bus cycle runs, and `cpu_done` for one cycle when an access completes. The IDE data bus is split into an input, an output and an output enable, which stands in for the tri-state control.

Top module: `ide_byte_bridge`

## Requirements
- R1: After reset, `ide_rst_n` is 0, `ide_cs1_n` and `ide_cs3_n` are 1, `ide_rd_n` and `ide_wr_n` are 1, `cpu_busy` is 0 and `ide_dout_en` is 0.
- R2: A write to port code 0 sets `ide_addr` from data bits 2:0, `ide_cs1_n` from bit 3, `ide_cs3_n` from bit 4 and `ide_rst_n` from bit 5. Bits 7:6 are ignored. The selects follow their bits only when exactly one of bits 3 and 4 is 0.
- R3: When bits 3 and 4 are both 0 or both 1, both selects are driven 1. An access that would start an IDE cycle produces no strobe, completes with `cpu_done` one cycle after acceptance, and a read returns 0xFF.
- R4: In word mode, a read of port code 1 runs an IDE read. It returns `ide_din[15:8]` and loads `ide_din[7:0]` into the latch.
- R5: In word mode, a read of port code 2 returns the latch, starts no IDE cycle, and completes one cycle after acceptance.
- R6: In word mode, a write to port code 1 loads the latch and starts no IDE cycle.
- R7: In word mode, a write to port code 2 runs an IDE write with `ide_dout` = {latch, written byte}. `ide_dout_en` is 1 only during the strobe and hold phases of a write.
- R8: An IDE cycle holds address and selects for SETUP_CLKS cycles before the strobe, keeps the strobe low for STROBE_CLKS cycles, and holds for HOLD_CLKS cycles after it. `ide_addr` and the selects stay stable throughout. `cpu_busy` is 1 for the whole cycle and `cpu_done` pulses in the cycle after.
- R9: With `byte_mode` = 1, a read or write on either data port runs one IDE transfer. A read returns `ide_din[7:0]`, a write drives `ide_dout` = {8'h00, written byte}, and the latch is unchanged.
- R10: Port code 3, and reads of port code 0, have no effect. They complete one cycle after acceptance and reads return 0x00.
- R11: A request presented while `cpu_busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_mode | input | 1 | 1 selects 8-bit-only transfers |
| cpu_req | input | 1 | Access request, taken when not busy |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_port | input | 2 | 0 control, 1 data high/latch, 2 data low/trigger, 3 unused |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte, valid with cpu_done |
| cpu_busy | output | 1 | IDE bus cycle in progress |
| cpu_done | output | 1 | Access complete pulse |
| ide_addr | output | 3 | IDE register address |
| ide_cs1_n | output | 1 | Command block select, active low |
| ide_cs3_n | output | 1 | Control block select, active low |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_rst_n | output | 1 | Device reset, active low |
| ide_din | input | 16 | IDE data bus in |
| ide_dout | output | 16 | IDE data bus out |
| ide_dout_en | output | 1 | IDE data bus drive enable |

## Verification
The bench targets the port/direction asymmetry. A design that triggers on the wrong direction would strobe on a latch write, or return stale data from a read of port 1. Invalid select codes are driven with both bits clear and both bits set: a design that forwards them would show both selects active, or a strobe with no select. Byte mode is followed by a latch readback in word mode, which catches a design that lets 8-bit transfers overwrite the latch. A request pushed in during a busy cycle exposes a design that reloads the control register mid-cycle.

// File: rtl/ide_bridge_pkg.sv
// Package: shared port codes and sequencer phase type for the IDE bridge.
package ide_bridge_pkg;
    localparam logic [1:0] PORT_CTRL = 2'd0;
    localparam logic [1:0] PORT_HI   = 2'd1;
    localparam logic [1:0] PORT_LO   = 2'd2;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_t;
endpackage

// File: rtl/ide_ctrl_reg.sv
// ide_ctrl_reg: write-only control register holding the IDE register
// address, the two select bits and the device reset bit.
// Assumes: load is a single-cycle pulse issued only while no IDE cycle runs.
// Selects are driven active only when exactly one is requested.
module ide_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [5:0] wdata,
    output logic [2:0] addr,
    output logic       cs1_n,
    output logic       cs3_n,
    output logic       dev_rst_n,
    output logic       sel_ok
);
    logic [5:0] ctrl_q;

    // Control register update; clears to zero, which holds the device in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (load) ctrl_q <= wdata;
    end

    // Decode the select pair; an invalid pair releases both lines.
    always_comb begin
        sel_ok    = ctrl_q[3] ^ ctrl_q[4];
        cs1_n     = sel_ok ? ctrl_q[3] : 1'b1;
        cs3_n     = sel_ok ? ctrl_q[4] : 1'b1;
        addr      = ctrl_q[2:0];
        dev_rst_n = ctrl_q[5];
    end

    // R2
    rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (dev_rst_n == $past(wdata[5])));
    // R3
    sel_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs1_n == 1'b0 && cs3_n == 1'b0));
endmodule

// File: rtl/ide_strobe_seq.sv
// ide_strobe_seq: runs one IDE bus cycle as setup, strobe and hold phases
// of parameterised length, driving the read or write strobe.
// Assumes: start is only raised while busy is 0; every length is at least 1.
module ide_strobe_seq
    import ide_bridge_pkg::*;
#(
    parameter int SETUP_CLKS  = 2,
    parameter int STROBE_CLKS = 3,
    parameter int HOLD_CLKS   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_write,
    output logic busy,
    output logic rd_n,
    output logic wr_n,
    output logic drive_en,
    output logic capture,
    output logic finish
);
    localparam int MAX_A = (SETUP_CLKS > STROBE_CLKS) ? SETUP_CLKS : STROBE_CLKS;
    localparam int MAX_C = (MAX_A > HOLD_CLKS) ? MAX_A : HOLD_CLKS;
    localparam int CW    = (MAX_C > 1) ? $clog2(MAX_C) : 1;

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic          wr_q;

    // Phase and length counter advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            wr_q  <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= PH_SETUP;
                    cnt   <= CW'(SETUP_CLKS - 1);
                    wr_q  <= start_write;
                end
                PH_SETUP: if (cnt == '0) begin
                    phase <= PH_STROBE;
                    cnt   <= CW'(STROBE_CLKS - 1);
                end else cnt <= cnt - 1'b1;
                PH_STROBE: if (cnt == '0) begin
                    phase <= PH_HOLD;
                    cnt   <= CW'(HOLD_CLKS - 1);
                end else cnt <= cnt - 1'b1;
                PH_HOLD: if (cnt == '0) phase <= PH_IDLE;
                         else cnt <= cnt - 1'b1;
            endcase
        end
    end

    // Strobe, drive and event outputs from the current phase.
    always_comb begin
        busy     = (phase != PH_IDLE);
        rd_n     = !(phase == PH_STROBE && !wr_q);
        wr_n     = !(phase == PH_STROBE && wr_q);
        drive_en = wr_q && (phase == PH_STROBE || phase == PH_HOLD);
        capture  = (phase == PH_STROBE) && (cnt == '0) && !wr_q;
        finish   = (phase == PH_HOLD) && (cnt == '0);
    end

    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    // R7
    drive_wr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> rd_n);
    // R8
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> busy);
endmodule

// File: rtl/ide_byte_bridge.sv
// ide_byte_bridge: maps three CPU byte ports onto a 16-bit IDE device.
// Port 1 read and port 2 write trigger IDE cycles; the other data accesses
// use a byte latch. byte_mode selects single 8-bit transfers.
// Assumes: cpu_req is honoured only when cpu_busy is 0; byte_mode changes
// only while idle.
module ide_byte_bridge
    import ide_bridge_pkg::*;
#(
    parameter int SETUP_CLKS  = 2,
    parameter int STROBE_CLKS = 3,
    parameter int HOLD_CLKS   = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_mode,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_port,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_busy,
    output logic        cpu_done,
    output logic [2:0]  ide_addr,
    output logic        ide_cs1_n,
    output logic        ide_cs3_n,
    output logic        ide_rd_n,
    output logic        ide_wr_n,
    output logic        ide_rst_n,
    input  logic [15:0] ide_din,
    output logic [15:0] ide_dout,
    output logic        ide_dout_en
);
    logic       accept, is_data, wants_cycle, trigger, ctrl_load, sel_ok;
    logic       capture, finish;
    logic [7:0] latch_q, wbyte_q, rdata_q;
    logic       xfer_byte_q, done_q;

    // Decode the accepted access and whether it needs an IDE cycle.
    always_comb begin
        accept      = cpu_req && !cpu_busy;
        is_data     = (cpu_port == PORT_HI) || (cpu_port == PORT_LO);
        wants_cycle = byte_mode ? is_data
                    : ((cpu_port == PORT_HI && !cpu_we) || (cpu_port == PORT_LO && cpu_we));
        trigger     = accept && wants_cycle && sel_ok;
        ctrl_load   = accept && cpu_we && (cpu_port == PORT_CTRL);
    end

    ide_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .load(ctrl_load), .wdata(cpu_wdata[5:0]),
        .addr(ide_addr), .cs1_n(ide_cs1_n), .cs3_n(ide_cs3_n),
        .dev_rst_n(ide_rst_n), .sel_ok(sel_ok)
    );

    ide_strobe_seq #(
        .SETUP_CLKS(SETUP_CLKS), .STROBE_CLKS(STROBE_CLKS), .HOLD_CLKS(HOLD_CLKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(trigger), .start_write(cpu_we),
        .busy(cpu_busy), .rd_n(ide_rd_n), .wr_n(ide_wr_n),
        .drive_en(ide_dout_en), .capture(capture), .finish(finish)
    );

    // Latch and transfer-context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q     <= '0;
            wbyte_q     <= '0;
            xfer_byte_q <= 1'b0;
        end else begin
            if (trigger) begin
                wbyte_q     <= cpu_wdata;
                xfer_byte_q <= byte_mode;
            end
            if (accept && cpu_we && cpu_port == PORT_HI && !byte_mode)
                latch_q <= cpu_wdata;
            else if (capture && !xfer_byte_q)
                latch_q <= ide_din[7:0];
        end
    end

    // Read data and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (accept && !trigger) || finish;
            if (capture)
                rdata_q <= xfer_byte_q ? ide_din[7:0] : ide_din[15:8];
            else if (accept && !trigger && !cpu_we) begin
                if (wants_cycle)                                 rdata_q <= 8'hFF;
                else if (cpu_port == PORT_LO && !byte_mode)      rdata_q <= latch_q;
                else                                             rdata_q <= 8'h00;
            end
        end
    end

    assign cpu_rdata = rdata_q;
    assign cpu_done  = done_q;
    assign ide_dout  = xfer_byte_q ? {8'h00, wbyte_q} : {latch_q, wbyte_q};

    // R3
    no_strobe_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_cs1_n && ide_cs3_n) |-> (ide_rd_n && ide_wr_n));
    // R8
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_busy && $past(cpu_busy)) |-> ($stable(ide_addr) && $stable(ide_cs1_n) && $stable(ide_cs3_n)));
    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !cpu_busy);
    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_busy) |-> cpu_done);
endmodule

// File: tb/ide_byte_bridge_tb.sv
module ide_byte_bridge_tb;
    logic        clk = 1'b0, rst_n = 1'b0, byte_mode = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [1:0]  cpu_port = 2'd0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        cpu_busy, cpu_done;
    logic [2:0]  ide_addr;
    logic        ide_cs1_n, ide_cs3_n, ide_rd_n, ide_wr_n, ide_rst_n, ide_dout_en;
    logic [15:0] ide_din = 16'h0000, ide_dout;

    int errors = 0, checks = 0, cyc = 0;
    int n_busy, n_setup, n_rd, n_wr, n_oe;
    logic [15:0] obs_dout;
    logic [7:0]  obs_rdata;
    logic        moved;

    always #4 clk = ~clk;

    ide_byte_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_port(cpu_port), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_busy(cpu_busy), .cpu_done(cpu_done),
        .ide_addr(ide_addr), .ide_cs1_n(ide_cs1_n), .ide_cs3_n(ide_cs3_n),
        .ide_rd_n(ide_rd_n), .ide_wr_n(ide_wr_n), .ide_rst_n(ide_rst_n),
        .ide_din(ide_din), .ide_dout(ide_dout), .ide_dout_en(ide_dout_en)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1; checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<100000", cyc);
            summary();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Observe one accepted access until cpu_done, sampling at falling edges.
    task automatic observe();
        logic [2:0] a0; logic c1, c3; logic first;
        n_busy = 0; n_setup = 0; n_rd = 0; n_wr = 0; n_oe = 0;
        obs_dout = 16'h0; moved = 1'b0; first = 1'b1;
        a0 = ide_addr; c1 = ide_cs1_n; c3 = ide_cs3_n;
        for (int i = 0; i < 60; i++) begin
            if (cpu_done) break;
            if (cpu_busy) begin
                n_busy++;
                if (first) begin a0 = ide_addr; c1 = ide_cs1_n; c3 = ide_cs3_n; first = 1'b0; end
                else if (ide_addr != a0 || ide_cs1_n != c1 || ide_cs3_n != c3) moved = 1'b1;
            end
            if (!ide_rd_n) n_rd++;
            if (!ide_wr_n) begin n_wr++; obs_dout = ide_dout; end
            if (ide_dout_en) n_oe++;
            if (cpu_busy && ide_rd_n && ide_wr_n && n_rd == 0 && n_wr == 0) n_setup++;
            @(negedge clk);
        end
        obs_rdata = cpu_rdata;
    endtask

    task automatic access(input logic [1:0] port, input logic we, input logic [7:0] wd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_port = port; cpu_we = we; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        observe();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ide_rst_n", ide_rst_n, 0);
        chk("R1 cs1_n", ide_cs1_n, 1);
        chk("R1 cs3_n", ide_cs3_n, 1);
        chk("R1 strobes", {ide_rd_n, ide_wr_n}, 2'b11);
        chk("R1 busy", cpu_busy, 0);
        chk("R1 dout_en", ide_dout_en, 0);
    endtask

    task automatic t_ctrl();
        access(2'd0, 1'b1, 8'hF3);
        chk("R2 addr", ide_addr, 3);
        chk("R2 cs1_n", ide_cs1_n, 0);
        chk("R2 cs3_n", ide_cs3_n, 1);
        chk("R2 rst_n", ide_rst_n, 1);
        access(2'd0, 1'b1, 8'h2E);
        chk("R2 addr2", ide_addr, 6);
        chk("R2 cs pair2", {ide_cs1_n, ide_cs3_n}, 2'b10);
    endtask

    task automatic t_invalid_sel();
        ide_din = 16'h1357;
        access(2'd0, 1'b1, 8'h20);
        chk("R3 both-requested cs", {ide_cs1_n, ide_cs3_n}, 2'b11);
        access(2'd1, 1'b0, 8'h00);
        chk("R3 no read strobe", n_rd, 0);
        chk("R3 no busy", n_busy, 0);
        chk("R3 rdata FF", obs_rdata, 8'hFF);
        access(2'd0, 1'b1, 8'h38);
        chk("R3 neither cs", {ide_cs1_n, ide_cs3_n}, 2'b11);
        access(2'd2, 1'b1, 8'h99);
        chk("R3 no write strobe", n_wr + n_oe, 0);
    endtask

    task automatic t_word_read();
        access(2'd0, 1'b1, 8'h30);
        ide_din = 16'hA55A;
        access(2'd1, 1'b0, 8'h00);
        chk("R4 rdata high", obs_rdata, 8'hA5);
        chk("R8 setup", n_setup, 2);
        chk("R8 strobe", n_rd, 3);
        chk("R8 busy len", n_busy, 6);
        chk("R8 stable", moved, 0);
        ide_din = 16'h0000;
        access(2'd2, 1'b0, 8'h00);
        chk("R5 latch low", obs_rdata, 8'h5A);
        chk("R5 no cycle", n_busy, 0);
    endtask

    task automatic t_word_write();
        access(2'd1, 1'b1, 8'h12);
        chk("R6 no cycle", n_busy + n_wr, 0);
        access(2'd2, 1'b0, 8'h00);
        chk("R6 latch readback", obs_rdata, 8'h12);
        access(2'd2, 1'b1, 8'h34);
        chk("R7 wr strobe", n_wr, 3);
        chk("R7 dout", obs_dout, 16'h1234);
        chk("R7 dout_en len", n_oe, 4);
        chk("R7 no rd", n_rd, 0);
        chk("R7 released", ide_dout_en, 0);
    endtask

    task automatic t_byte_mode();
        byte_mode = 1'b1;
        ide_din = 16'hBEEF;
        access(2'd1, 1'b0, 8'h00);
        chk("R9 read hi port", obs_rdata, 8'hEF);
        chk("R9 strobe hi", n_rd, 3);
        access(2'd2, 1'b0, 8'h00);
        chk("R9 read lo port", obs_rdata, 8'hEF);
        chk("R9 strobe lo", n_rd, 3);
        access(2'd1, 1'b1, 8'h56);
        chk("R9 write hi port strobe", n_wr, 3);
        chk("R9 write dout", obs_dout, 16'h0056);
        byte_mode = 1'b0;
        access(2'd2, 1'b0, 8'h00);
        chk("R9 latch kept", obs_rdata, 8'h12);
    endtask

    task automatic t_unused_port();
        access(2'd3, 1'b0, 8'h00);
        chk("R10 port3 read", obs_rdata, 8'h00);
        chk("R10 port3 no cycle", n_busy, 0);
        access(2'd0, 1'b0, 8'h00);
        chk("R10 ctrl read", obs_rdata, 8'h00);
        access(2'd3, 1'b1, 8'hFF);
        chk("R10 ctrl kept", {ide_addr, ide_cs1_n, ide_cs3_n, ide_rst_n}, {3'd0, 1'b0, 1'b1, 1'b1});
    endtask

    task automatic t_busy_ignore();
        ide_din = 16'h4242;
        @(negedge clk);
        cpu_req = 1'b1; cpu_port = 2'd1; cpu_we = 1'b0;
        @(negedge clk);
        cpu_port = 2'd0; cpu_we = 1'b1; cpu_wdata = 8'h28;
        @(negedge clk);
        cpu_req = 1'b0;
        observe();
        @(negedge clk);
        chk("R11 ctrl untouched", {ide_cs1_n, ide_cs3_n}, 2'b01);
        chk("R11 read ok", obs_rdata, 8'h42);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ctrl();
        t_invalid_sel();
        t_word_read();
        t_word_write();
        t_byte_mode();
        t_unused_port();
        t_busy_ignore();
        summary();
    end
endmodule